// File: doc/BRIEF.md
# Sector Header Capture Writer

This block sits between a disc sector decoder and a 16 KB sector buffer. Each time the decoder reports a finished sector, the block latches the sector's 4-byte header and marks a decode as complete. It does this through a status byte and an active-low pending flag. When storing is enabled, the block also moves its block pointer and its write address forward by one full raw sector length, which is 2352 bytes. It then writes the header and then 2048 payload bytes into the buffer through a byte-wide write port, starting at the new pointer's buffer offset. A write that runs past the end of the buffer continues from address 0.

The payload bytes come in on a valid/ready byte stream. A one-cycle pulse marks the end of each store. A second pulse, the "next sector" request, tells the upstream source to move on. That pulse is raised only when storing was enabled; otherwise the source keeps presenting the same sector. While a store is still running, new sector events are dropped. The reset values of both pointers are parameters.

Top module: `sector_capture_writer`

## Requirements
- R1: A sector event that arrives while `decode_en` is low has no effect: the header bank, status byte, pending flag, both pointers, `next_sector` and `mem_we` all keep their values.
- R2: From reset, `hdr_bank` is 0x01000000, `hdr_status` is 0x80 and `decode_pend_n` is 1. An accepted event copies `sector_hdr` into `hdr_bank`, sets `hdr_status` to 0x00 and drives `decode_pend_n` low, all visible in the cycle after the event.
- R3: An accepted event with `store_en` high adds 2352 to both `blk_ptr` and `wr_addr`, modulo 65536, visible in the cycle after the event.
- R4: Each store writes 2052 bytes to consecutive buffer addresses. It starts at the new `blk_ptr` ANDed with 0x3FFF. The first four writes are the header bytes in order `sector_hdr[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`, one per cycle, beginning the cycle after the event. The 2048 stream bytes follow.
- R5: A buffer address that would reach 0x4000 continues from 0x0000 (addresses are taken modulo 16384).
- R6: `next_sector` is a one-cycle pulse in the cycle after an accepted event, and only when `store_en` was high. An accepted event with `store_en` low leaves the pointers unchanged and produces no buffer writes.
- R7: `dat_ready` is high only while payload bytes are being taken. Every cycle with `dat_valid` and `dat_ready` both high writes exactly one byte (`mem_wdata` = `dat_byte`). No write happens in a payload cycle without `dat_valid`.
- R8: `store_done` pulses for one cycle, in the cycle after the 2048th payload byte is accepted. The block is idle from that cycle on.
- R9: A sector event that arrives while a store is in progress is ignored. This includes the cycle in which the last payload byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decode_en | input | 1 | Decoding enable; sector events are dropped when low |
| store_en | input | 1 | Buffer store enable |
| sector_evt | input | 1 | One-cycle pulse: a sector has been decoded |
| sector_hdr | input | 32 | Header of the decoded sector, byte 0 in bits 7:0 |
| dat_valid | input | 1 | Payload byte available |
| dat_byte | input | 8 | Payload byte |
| dat_ready | output | 1 | Block takes a payload byte this cycle if valid |
| hdr_bank | output | 32 | Latched header of the last accepted sector |
| hdr_status | output | 8 | Status byte: 0x80 idle, 0x00 after a capture |
| decode_pend_n | output | 1 | Active-low decode-complete flag |
| blk_ptr | output | 16 | Block pointer |
| wr_addr | output | 16 | Write address |
| next_sector | output | 1 | Pulse: upstream may advance to the next sector |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | 14 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| store_done | output | 1 | Pulse: a store has finished |

## Verification
The interesting collision is a new sector event landing in the same cycle as the last payload byte. In that cycle the store is ending but is still busy, so the event must be dropped while the final write and the done pulse still happen. The bench provokes this by streaming with `dat_valid` held high and raising `sector_evt` exactly when its reference model sits on the final byte. The per-cycle comparison then requires no header, status or pointer change, a single `store_done`, and no new header writes. A second overlap is an event in the middle of a gappy stream, where the bench checks that the write addresses keep their sequence across the buffer's wrap point.

// File: rtl/sctw_pkg.sv
package sctw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HEAD = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/sctw_hdr_latch.sv
module sctw_hdr_latch #(
  parameter int unsigned          HDR_W     = 32,
  parameter logic [HDR_W-1:0]     HDR_RESET = 32'h0100_0000,
  parameter logic [7:0]           STAT_IDLE = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [HDR_W-1:0] hdr_in,
  output logic [HDR_W-1:0] hdr_q,
  output logic [7:0]       stat_q,
  output logic             pend_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= HDR_RESET;
      stat_q <= STAT_IDLE;
      pend_n <= 1'b1;
    end else if (capture) begin
      hdr_q  <= hdr_in;
      stat_q <= 8'h00;
      pend_n <= 1'b0;
    end
  end

  // R2: capture reaches all three outputs one cycle later
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (hdr_q == $past(hdr_in)) && (stat_q == 8'h00) && !pend_n);

endmodule

// File: rtl/sctw_ptr_unit.sv
module sctw_ptr_unit #(
  parameter int unsigned      PTR_W     = 16,
  parameter int unsigned      BUF_AW    = 14,
  parameter int unsigned      STRIDE    = 2352,
  parameter logic [PTR_W-1:0] PTR_RESET = '0,
  parameter logic [PTR_W-1:0] WA_RESET  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [PTR_W-1:0]  blk_ptr,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BUF_AW-1:0] store_base,
  output logic              next_sec
);

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return p + PTR_W'(STRIDE);
  endfunction

  logic [PTR_W-1:0] ptr_next;

  assign ptr_next   = step(blk_ptr);
  assign store_base = ptr_next[BUF_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_ptr  <= PTR_RESET;
      wr_addr  <= WA_RESET;
      next_sec <= 1'b0;
    end else begin
      next_sec <= adv;
      if (adv) begin
        blk_ptr <= ptr_next;
        wr_addr <= step(wr_addr);
      end
    end
  end

  // R3: both pointers move by one stride together
  a_r3_stride: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (blk_ptr == $past(blk_ptr) + PTR_W'(STRIDE)) &&
            (wr_addr == $past(wr_addr) + PTR_W'(STRIDE)));

  // R6: pointers hold when no advance
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(blk_ptr) && $stable(wr_addr) && !next_sec);

endmodule

// File: rtl/sctw_store_seq.sv
module sctw_store_seq
  import sctw_pkg::*;
#(
  parameter int unsigned HDR_BYTES  = 4,
  parameter int unsigned DATA_BYTES = 2048,
  parameter int unsigned BUF_AW     = 14,
  localparam int unsigned HDR_W     = 8 * HDR_BYTES,
  localparam int unsigned TOTAL     = HDR_BYTES + DATA_BYTES,
  localparam int unsigned IDX_W     = $clog2(TOTAL),
  localparam int unsigned HSEL_W    = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUF_AW-1:0] base,
  input  logic [HDR_W-1:0]  hdr,
  input  logic              dat_valid,
  input  logic [7:0]        dat_byte,
  output logic              dat_ready,
  output logic              busy,
  output logic              mem_we,
  output logic [BUF_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              done
);

  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic [BUF_AW-1:0] base_q;
  logic [HDR_W-1:0]  hdr_q;
  logic              in_head;
  logic              xfer;
  logic              last_xfer;
  logic [HSEL_W-1:0] hsel;
  logic [31:0]       addr_sum;

  function automatic logic [7:0] hdr_byte(input logic [HDR_W-1:0] h,
                                          input logic [HSEL_W-1:0] k);
    return h[{k, 3'b000} +: 8];
  endfunction

  assign in_head   = (phase == PH_HEAD);
  assign dat_ready = (phase == PH_DATA);
  assign busy      = (phase != PH_IDLE);
  assign xfer      = dat_ready && dat_valid;
  assign last_xfer = xfer && (idx == IDX_W'(TOTAL - 1));
  assign hsel      = idx[HSEL_W-1:0];
  assign addr_sum  = 32'(base_q) + 32'(idx);
  assign mem_addr  = addr_sum[BUF_AW-1:0];
  assign mem_we    = in_head || xfer;
  assign mem_wdata = in_head ? hdr_byte(hdr_q, hsel) : dat_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      base_q <= '0;
      hdr_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_HEAD;
          idx    <= '0;
          base_q <= base;
          hdr_q  <= hdr;
        end
        PH_HEAD: begin
          idx <= idx + 1'b1;
          if (idx == IDX_W'(HDR_BYTES - 1)) phase <= PH_DATA;
        end
        PH_DATA: if (xfer) begin
          idx <= idx + 1'b1;
          if (last_xfer) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4: first write of a store lands on the captured base with header byte 0
  a_r4_first_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> mem_we && (mem_addr == $past(base)) &&
                         (mem_wdata == $past(hdr[7:0])));

  // R5: addresses within one store are consecutive modulo the buffer size
  a_r5_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && busy && $past(mem_we) && $past(busy)) |->
      (mem_addr == $past(mem_addr) + 1'b1));

  // R7: no write in a payload cycle without valid data
  a_r7_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_ready && !dat_valid) |-> !mem_we);

  // R8: done follows the final accepted byte and leaves the sequencer idle
  a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(xfer));

endmodule

// File: rtl/sector_capture_writer.sv
module sector_capture_writer #(
  parameter int unsigned  PTR_W      = 16,
  parameter int unsigned  BUF_AW     = 14,
  parameter int unsigned  HDR_BYTES  = 4,
  parameter int unsigned  DATA_BYTES = 2048,
  parameter int unsigned  STRIDE     = 2352,
  parameter logic [15:0]  PTR_RESET  = 16'h0000,
  parameter logic [15:0]  WA_RESET   = 16'h0000,
  localparam int unsigned HDR_W      = 8 * HDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decode_en,
  input  logic              store_en,
  input  logic              sector_evt,
  input  logic [HDR_W-1:0]  sector_hdr,
  input  logic              dat_valid,
  input  logic [7:0]        dat_byte,
  output logic              dat_ready,
  output logic [HDR_W-1:0]  hdr_bank,
  output logic [7:0]        hdr_status,
  output logic              decode_pend_n,
  output logic [PTR_W-1:0]  blk_ptr,
  output logic [PTR_W-1:0]  wr_addr,
  output logic              next_sector,
  output logic              mem_we,
  output logic [BUF_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              store_done
);

  logic              busy;
  logic              accept;
  logic              store_go;
  logic [BUF_AW-1:0] store_base;

  assign accept   = sector_evt && decode_en && !busy;
  assign store_go = accept && store_en;

  sctw_hdr_latch #(
    .HDR_W     (HDR_W),
    .HDR_RESET (HDR_W'(32'h0100_0000)),
    .STAT_IDLE (8'h80)
  ) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .hdr_in  (sector_hdr),
    .hdr_q   (hdr_bank),
    .stat_q  (hdr_status),
    .pend_n  (decode_pend_n)
  );

  sctw_ptr_unit #(
    .PTR_W     (PTR_W),
    .BUF_AW    (BUF_AW),
    .STRIDE    (STRIDE),
    .PTR_RESET (PTR_W'(PTR_RESET)),
    .WA_RESET  (PTR_W'(WA_RESET))
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (store_go),
    .blk_ptr    (blk_ptr),
    .wr_addr    (wr_addr),
    .store_base (store_base),
    .next_sec   (next_sector)
  );

  sctw_store_seq #(
    .HDR_BYTES  (HDR_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .BUF_AW     (BUF_AW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (store_go),
    .base      (store_base),
    .hdr       (sector_hdr),
    .dat_valid (dat_valid),
    .dat_byte  (dat_byte),
    .dat_ready (dat_ready),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (store_done)
  );

  // R1: events with decoding off leave visible state untouched
  a_r1_decode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_evt && !decode_en) |=> $stable(hdr_bank) && $stable(hdr_status) &&
                                   $stable(blk_ptr) && !next_sector);

  // R6: the advance request only follows an event taken with storing on
  a_r6_next_cause: assert property (@(posedge clk) disable iff (!rst_n)
    next_sector |-> $past(sector_evt) && $past(store_en) && $past(decode_en));

  // R9: an event during a store changes neither header nor pointers
  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_evt && busy) |=> $stable(hdr_bank) && $stable(wr_addr) &&
                             $stable(blk_ptr) && !next_sector);

endmodule

// File: tb/test_sector_capture_writer.sv
`timescale 1ns/1ps
module test_sector_capture_writer;

  localparam logic [15:0] P0 = 16'hF000;
  localparam logic [15:0] W0 = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        decode_en, store_en, sector_evt;
  logic [31:0] sector_hdr;
  logic        dat_valid;
  logic [7:0]  dat_byte;
  logic        dat_ready;
  logic [31:0] hdr_bank;
  logic [7:0]  hdr_status;
  logic        decode_pend_n;
  logic [15:0] blk_ptr, wr_addr;
  logic        next_sector, mem_we, store_done;
  logic [13:0] mem_addr;
  logic [7:0]  mem_wdata;

  always #2 clk = ~clk;

  sector_capture_writer #(.PTR_RESET(P0), .WA_RESET(W0)) i_sector_capture_writer (
    .clk(clk), .rst_n(rst_n), .decode_en(decode_en), .store_en(store_en),
    .sector_evt(sector_evt), .sector_hdr(sector_hdr), .dat_valid(dat_valid),
    .dat_byte(dat_byte), .dat_ready(dat_ready), .hdr_bank(hdr_bank),
    .hdr_status(hdr_status), .decode_pend_n(decode_pend_n), .blk_ptr(blk_ptr),
    .wr_addr(wr_addr), .next_sector(next_sector), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .store_done(store_done)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit started = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  longint m_hdr, m_ptr, m_wa, m_base;
  int     m_stat, m_idx, src_cnt;
  bit     m_pend, m_next, m_done, m_busy;

  always @(posedge clk) begin
    int np;
    if (!rst_n) begin
      m_hdr <= 32'h0100_0000; m_stat <= 8'h80; m_pend <= 1;
      m_ptr <= P0; m_wa <= W0; m_base <= 0;
      m_next <= 0; m_done <= 0; m_busy <= 0; m_idx <= 0; src_cnt <= 0;
    end else begin
      m_next <= 0;
      m_done <= 0;
      if (m_busy) begin
        if (m_idx < 4) m_idx <= m_idx + 1;
        else if (dat_valid) begin
          m_idx   <= m_idx + 1;
          src_cnt <= src_cnt + 1;
          if (m_idx == 2051) begin m_busy <= 0; m_done <= 1; end
        end
      end
      if (sector_evt && decode_en && !m_busy) begin
        m_hdr <= sector_hdr; m_stat <= 0; m_pend <= 0;
        if (store_en) begin
          np = int'((m_ptr + 2352) % 65536);
          m_ptr  <= np;
          m_wa   <= (m_wa + 2352) % 65536;
          m_base <= np % 16384;
          m_busy <= 1; m_idx <= 0; m_next <= 1;
        end
      end
    end
  end

  // payload source
  bit         src_always;
  logic [31:0] lf = 32'h1ACE_B00C;
  always @(negedge clk) begin
    lf = lf * 32'd1103515245 + 32'd12345;
    dat_valid = src_always ? 1'b1 : lf[17] | lf[5];
    dat_byte  = 8'(src_cnt) ^ 8'hA5;
  end

  // per-cycle comparison
  always begin
    @(negedge clk);
    #1;
    if (rst_n && started) begin
      bit exp_we;
      longint a;
      exp_we = m_busy && (m_idx < 4 || dat_valid);
      chk("R2 hdr_bank", hdr_bank, m_hdr);
      chk("R2 hdr_status", hdr_status, m_stat);
      chk("R2 decode_pend_n", decode_pend_n, m_pend);
      chk("R3 blk_ptr", blk_ptr, m_ptr);
      chk("R3 wr_addr", wr_addr, m_wa);
      chk("R6 next_sector", next_sector, m_next);
      chk("R8 store_done", store_done, m_done);
      chk("R7 dat_ready", dat_ready, m_busy && m_idx >= 4);
      chk("R6/R7 mem_we", mem_we, exp_we);
      if (exp_we) begin
        a = m_base + m_idx;
        if (a >= 16384) chk("R5 mem_addr wrap", mem_addr, a - 16384);
        else            chk("R4 mem_addr", mem_addr, a);
        if (m_idx < 4) chk("R4 header byte", mem_wdata, (m_hdr >> (8 * m_idx)) & 255);
        else           chk("R7 payload byte", mem_wdata, dat_byte);
      end
    end
  end

  task automatic pulse_evt(input logic [31:0] h);
    @(negedge clk);
    sector_evt = 1'b1; sector_hdr = h;
    @(negedge clk);
    sector_evt = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 120000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        report();
      end
    end
  end

  initial begin
    rst_n = 0; decode_en = 0; store_en = 0; sector_evt = 0;
    sector_hdr = '0; src_always = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset values
    chk("R2 reset hdr_bank", hdr_bank, 32'h0100_0000);
    chk("R2 reset hdr_status", hdr_status, 8'h80);
    chk("R2 reset decode_pend_n", decode_pend_n, 1);
    chk("R3 reset blk_ptr", blk_ptr, P0);
    started = 1;

    // R1: decoding off
    store_en = 1;
    pulse_evt(32'hDEAD_BEEF);
    repeat (3) @(negedge clk);
    chk("R1 hdr untouched", hdr_bank, 32'h0100_0000);
    chk("R1 ptr untouched", blk_ptr, P0);
    chk("R1 status untouched", hdr_status, 8'h80);

    // R6: decode without storing
    decode_en = 1; store_en = 0;
    pulse_evt(32'h1122_3344);
    repeat (3) @(negedge clk);
    chk("R6 ptr unchanged", blk_ptr, P0);
    chk("R2 header taken", hdr_bank, 32'h1122_3344);

    // R3/R4/R5: store crossing the buffer end, gappy stream, R9 mid-store event
    store_en = 1;
    pulse_evt(32'hA1B2_C3D4);
    repeat (10) @(negedge clk);
    pulse_evt(32'h5555_5555);
    wait_idle();
    chk("R9 mid-store event dropped", hdr_bank, 32'hA1B2_C3D4);
    chk("R3 pointer after first store", blk_ptr, 16'hF930);

    // R9: event on the last byte, solid stream, 16-bit pointer wrap
    src_always = 1;
    pulse_evt(32'h0BAD_F00D);
    do @(negedge clk); while (!(m_busy && m_idx == 2051));
    sector_evt = 1'b1; sector_hdr = 32'h9999_9999;
    @(negedge clk);
    sector_evt = 1'b0;
    wait_idle();
    chk("R9 last-byte event dropped", hdr_bank, 32'h0BAD_F00D);
    chk("R3 pointer 16-bit wrap", blk_ptr, 16'h0260);

    // third store, gappy again
    src_always = 0;
    pulse_evt(32'hC0FF_EE00);
    wait_idle();
    chk("R8 idle after store", dat_ready, 0);
    report();
  end

endmodule